// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands (53 bits each by default) into a double-width product. It uses one operand-width adder many times over instead of an array of adders. A one-cycle `start` pulse captures both operands and clears the running product. The block then consumes one bit of the multiplier per clock, from the least significant bit upward. When the current multiplier bit is set, the captured multiplicand is added into an operand-width slice of the product. That slice begins at the current bit position. The adder's carry-out is stored in the product bit just above the slice.

The block has no reset. Every operation is initialised by `start`, and `start` may be raised at any time to abandon the current operation and begin a new one. A build-time option lets the block stop as soon as the multiplier bits still to be processed are all zero, so small multipliers finish sooner. The product is valid while `done` is high. It holds, and `done` stays high, until the next `start`.

Top module: `seq_mul`

## Requirements
- R1: In the cycle after an edge that samples `start` high, `done` is 0 and `product` is all zeros.
- R2: When `done` is high, `product` equals the unsigned product `opA * opB` of the operands sampled at the last `start` edge.
- R3: With `EARLY_STOP = 0`, `done` first reads 1 exactly `OPW` clock edges after the last edge that sampled `start` high.
- R4: Once `done` is high and `start` stays low, `done` stays high and `product` does not change, even when `opA` and `opB` change.
- R5: Raising `start` while an operation is in progress abandons that operation. Both the result and the latency then follow the new start.
- R6: With `EARLY_STOP = 1`, `done` first reads 1 after max(1, h+1) edges following the start edge, where h is the index of the highest set bit of the captured `opB` (h+1 is taken as 0 when `opB` = 0).
- R7: With `EARLY_STOP = 1`, the product is still exactly `opA * opB`. This includes `opB` = 0, which gives a zero product.
- R8: The carry out of the slice is kept. All-ones operands give (2^OPW - 1)^2, whose top bit is 1.
- R9: If `start` is held high for several cycles, the operation uses the operands present at the last edge at which `start` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| start | input | 1 | Captures operands and begins a new multiplication |
| opA | input | OPW | Multiplicand, unsigned |
| opB | input | OPW | Multiplier, unsigned |
| product | output | 2*OPW | Double-width unsigned product |
| done | output | 1 | High once the product is complete, until the next start |

## Verification
Errors in the slice position, the carry placement or the multiplier shift register all end up in the product bits. They become visible at the port on the first cycle that `done` is high after the faulty operation. A wrong iteration count or a faulty stop condition moves the rising edge of `done` away from its computed cycle, so it is detected in that same operation. The bench sweeps every operand pair of a 5-bit build in both stop modes. It also runs corner and random operands on the full-width build, and the abort and held-start cases, so these errors appear within one operation.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic load;  // capture operands, clear product
    logic step;  // process one multiplier bit
  } mulStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mulState_t;

endpackage

// File: rtl/seqmul_adder.sv
// Operand-width adder with carry in and carry out.
// FAST = 0 builds an explicit ripple chain, FAST = 1 uses the operator.
module seqmul_adder #(
  parameter int W    = 53,
  parameter bit FAST = 1'b0
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut
);

  generate
    if (FAST) begin : g_op
      logic [W:0] wide;
      assign wide     = {1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, carryIn};
      assign sum      = wide[W-1:0];
      assign carryOut = wide[W];
    end else begin : g_ripple
      logic [W:0] chain;
      assign chain[0] = carryIn;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = addA[i] ^ addB[i] ^ chain[i];
        assign chain[i+1] = (addA[i] & addB[i]) | (chain[i] & (addA[i] ^ addB[i]));
      end
      assign carryOut = chain[W];
    end
  endgenerate

endmodule

// File: rtl/seqmul_datapath.sv
// Operand registers, multiplier shift register and product accumulator.
module seqmul_datapath
  import seqmul_pkg::*;
#(
  parameter int OPW        = 53,
  parameter bit ADDER_FAST = 1'b0,
  localparam int PW        = 2 * OPW,
  localparam int CW        = $clog2(OPW + 1),
  localparam int IW        = $clog2(PW)
) (
  input  logic            clk,
  input  mulStrobe_t      strobe,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic [CW-1:0]   count,
  output logic [PW-1:0]   product,
  output logic            restZero
);

  logic [OPW-1:0] mcandReg;
  logic [OPW-1:0] shiftReg;
  logic [PW-1:0]  prodReg;
  logic [PW-1:0]  prodNext;
  logic [IW-1:0]  winBase;
  logic [OPW-1:0] window;
  logic [OPW-1:0] winSum;
  logic           winCarry;

  assign winBase = IW'(count);
  assign window  = prodReg[winBase +: OPW];

  seqmul_adder #(.W(OPW), .FAST(ADDER_FAST)) uAdd (
    .addA    (mcandReg),
    .addB    (window),
    .carryIn (1'b0),
    .sum     (winSum),
    .carryOut(winCarry)
  );

  always_comb begin
    prodNext = prodReg;
    if (shiftReg[0]) begin
      prodNext[winBase +: OPW]          = winSum;
      prodNext[winBase + IW'(OPW)]      = winCarry;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      prodReg  <= '0;
      shiftReg <= opB;
      mcandReg <= opA;
    end else if (strobe.step) begin
      prodReg  <= prodNext;
      shiftReg <= shiftReg >> 1;
    end
  end

  // Bits still to be processed after the current one are all zero.
  assign restZero = (shiftReg >> 1) == '0;
  assign product  = prodReg;

endmodule

// File: rtl/seqmul_control.sv
// Iteration counter and run/finish sequencing.
module seqmul_control
  import seqmul_pkg::*;
#(
  parameter int OPW        = 53,
  parameter bit EARLY_STOP = 1'b0,
  localparam int CW        = $clog2(OPW + 1)
) (
  input  logic          clk,
  input  logic          start,
  input  logic          restZero,
  output mulStrobe_t    strobe,
  output logic [CW-1:0] count,
  output logic          done
);

  mulState_t state;
  logic      lastBit;
  logic      stopHere;

  assign lastBit = (count == CW'(OPW - 1));

  generate
    if (EARLY_STOP) begin : g_early
      assign stopHere = lastBit | restZero;
    end else begin : g_fixed
      assign stopHere = lastBit;
    end
  endgenerate

  always_comb begin
    strobe.load = start;
    strobe.step = !start && (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (start) begin
      state <= ST_RUN;
      count <= '0;
    end else if (strobe.step) begin
      count <= count + 1'b1;
      if (stopHere) state <= ST_FIN;
    end
  end

  assign done = (state == ST_FIN);

endmodule

// File: rtl/seq_mul.sv
// Iterative unsigned multiplier, top level.
module seq_mul
  import seqmul_pkg::*;
#(
  parameter int OPW        = 53,
  parameter bit EARLY_STOP = 1'b0,
  parameter bit ADDER_FAST = 1'b0,
  localparam int PW        = 2 * OPW,
  localparam int CW        = $clog2(OPW + 1)
) (
  input  logic           clk,
  input  logic           start,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  output logic [PW-1:0]  product,
  output logic           done
);

  mulStrobe_t    strobe;
  logic [CW-1:0] count;
  logic          restZero;

  seqmul_control #(.OPW(OPW), .EARLY_STOP(EARLY_STOP)) uCtrl (
    .clk     (clk),
    .start   (start),
    .restZero(restZero),
    .strobe  (strobe),
    .count   (count),
    .done    (done)
  );

  seqmul_datapath #(.OPW(OPW), .ADDER_FAST(ADDER_FAST)) uDp (
    .clk     (clk),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .count   (count),
    .product (product),
    .restZero(restZero)
  );

endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
  parameter int OPW        = 53,
  parameter bit EARLY_STOP = 1'b0,
  localparam int PW        = 2 * OPW
) (
  input logic           clk,
  input logic           start,
  input logic [OPW-1:0] opA,
  input logic [OPW-1:0] opB,
  input logic [PW-1:0]  product,
  input logic           done
);

  logic           armed = 1'b0;
  logic [OPW-1:0] capA;
  logic [OPW-1:0] capB;
  int             cyc;

  function automatic int expLatency(input logic [OPW-1:0] b);
    int h;
    h = 0;
    for (int i = 0; i < OPW; i++) if (b[i]) h = i + 1;
    return (h < 1) ? 1 : h;
  endfunction

  always_ff @(posedge clk) begin
    if (start) begin
      armed <= 1'b1;
      capA  <= opA;
      capB  <= opB;
      cyc   <= 0;
    end else if (!done) begin
      cyc <= cyc + 1;
    end
  end

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!armed)
    start |=> (!done && product == '0));

  // R2
  result_value_chk: assert property (@(posedge clk) disable iff (!armed)
    $rose(done) |-> (product == (PW'(capA) * PW'(capB))));

  // R3
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!armed)
    ($rose(done) && !EARLY_STOP) |-> (cyc == OPW));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (done && !start) |=> (done && $stable(product)));

  // R6
  early_latency_chk: assert property (@(posedge clk) disable iff (!armed)
    ($rose(done) && EARLY_STOP) |-> (cyc == expLatency(capB)));

endmodule

bind seq_mul seqmul_chk #(.OPW(OPW), .EARLY_STOP(EARLY_STOP)) uChk (
  .clk    (clk),
  .start  (start),
  .opA    (opA),
  .opB    (opB),
  .product(product),
  .done   (done)
);

// File: tb/sim_seq_mul.sv
`timescale 1ns/1ps
module sim_seq_mul;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // full-width fixed-latency build
  logic         st0 = 1'b0;
  logic [52:0]  a0 = '0, b0 = '0;
  logic [105:0] p0;
  logic         d0;

  // small builds: u1 early stop, u2 fixed
  logic         st1 = 1'b0;
  logic [4:0]   a1 = '0, b1 = '0;
  logic [9:0]   p1, p2;
  logic         d1, d2;

  seq_mul #(.OPW(53), .EARLY_STOP(1'b0), .ADDER_FAST(1'b0)) u0 (
    .clk(clk), .start(st0), .opA(a0), .opB(b0), .product(p0), .done(d0));
  seq_mul #(.OPW(5), .EARLY_STOP(1'b1), .ADDER_FAST(1'b1)) u1 (
    .clk(clk), .start(st1), .opA(a1), .opB(b1), .product(p1), .done(d1));
  seq_mul #(.OPW(5), .EARLY_STOP(1'b0), .ADDER_FAST(1'b0)) u2 (
    .clk(clk), .start(st1), .opA(a1), .opB(b1), .product(p2), .done(d2));

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int earlyLat(input logic [4:0] b);
    int h = 0;
    for (int i = 0; i < 5; i++) if (b[i]) h = i + 1;
    return (h < 1) ? 1 : h;
  endfunction

  // Wait for done on u0; returns edges counted after the start edge.
  task automatic waitWide(output int n);
    n = 0;
    while (!d0 && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runWide(input logic [52:0] a, input logic [52:0] b, input string req);
    int n;
    logic [105:0] e;
    @(negedge clk); a0 = a; b0 = b; st0 = 1'b1;
    @(negedge clk); st0 = 1'b0;
    check(d0 == 1'b0 && p0 == '0, "R1", {d0, p0}, 0);
    waitWide(n);
    e = {53'b0, a} * {53'b0, b};
    check(p0 == e, req, p0, e);
    check(n == 53, "R3", n, 53);
  endtask

  task automatic runSmall(input logic [4:0] a, input logic [4:0] b);
    int n1 = -1, n2 = -1, n = 0;
    logic [9:0] e;
    @(negedge clk); a1 = a; b1 = b; st1 = 1'b1;
    @(negedge clk); st1 = 1'b0;
    while ((n1 < 0 || n2 < 0) && n < 20) begin
      if (d1 && n1 < 0) n1 = n;
      if (d2 && n2 < 0) n2 = n;
      if (n1 < 0 || n2 < 0) begin
        @(negedge clk);
        n++;
      end
    end
    e = {5'b0, a} * {5'b0, b};
    check(p1 == e, "R7 early product", p1, e);
    check(n1 == earlyLat(b), "R6 early latency", n1, earlyLat(b));
    check(p2 == e, "R2 small product", p2, e);
    check(n2 == 5, "R3 small latency", n2, 5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [52:0] ones;
    logic [105:0] e;
    int n;
    ones = '1;

    // corner operands, full width
    runWide(53'd0, 53'd0, "R2 zero");
    runWide(53'd1, ones, "R2 one");
    runWide(ones, 53'd1, "R2 one");
    runWide(ones, ones, "R8 all ones");
    check(p0[105] == 1'b1, "R8 top bit", p0[105], 1);
    runWide(53'd1 << 52, 53'd1 << 52, "R8 top bits");

    // R4: operand changes after completion are ignored
    e = p0;
    @(negedge clk); a0 = 53'h1234; b0 = 53'h5678;
    repeat (3) @(negedge clk);
    check(d0 == 1'b1, "R4 done held", d0, 1);
    check(p0 == e, "R4 product held", p0, e);

    // random full-width operands
    for (int k = 0; k < 200; k++)
      runWide({$urandom, $urandom}, {$urandom, $urandom}, "R2 random");

    // R5: abort part way and restart
    @(negedge clk); a0 = ones; b0 = ones; st0 = 1'b1;
    @(negedge clk); st0 = 1'b0;
    repeat (10) @(negedge clk);
    check(d0 == 1'b0, "R5 busy before abort", d0, 0);
    runWide(53'h1F_FFFF_0000_1111, 53'h0A5A_5A5A_5A5A, "R5 restart");

    // R9: start held for three edges with changing operands
    @(negedge clk); a0 = 53'd7; b0 = 53'd9; st0 = 1'b1;
    @(negedge clk); a0 = 53'd11; b0 = 53'd13;
    @(negedge clk); a0 = 53'h1_0000_0001; b0 = 53'h3_0000_0005;
    @(negedge clk); st0 = 1'b0;
    check(d0 == 1'b0 && p0 == '0, "R9 cleared", {d0, p0}, 0);
    waitWide(n);
    e = {53'b0, 53'h1_0000_0001} * {53'b0, 53'h3_0000_0005};
    check(p0 == e, "R9 last operands", p0, e);
    check(n == 53, "R9 latency", n, 53);

    // exhaustive small builds, both stop modes
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        runSmall(a[4:0], b[4:0]);

    // R5 on the early-stop build: abort then restart with small multiplier
    @(negedge clk); a1 = 5'd31; b1 = 5'd31; st1 = 1'b1;
    @(negedge clk); st1 = 1'b0;
    @(negedge clk);
    runSmall(5'd21, 5'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule